// File: doc/BRIEF.md
# Dual-Issue Register Rename Unit

This block translates the architectural register names of up to two instructions per cycle into physical register tags. An alias table holds the current physical tag of each of the eight architectural registers. A first-in first-out list of free physical tags supplies a fresh tag to every instruction that writes a register. Write-after-write and write-after-read conflicts disappear, and true read-after-write chains are kept.

For each renamed instruction the unit gives the physical tags of both sources, the newly allocated destination tag and the tag that the destination held before. Later stages release that previous tag through the retire port once it is no longer needed. The pair is renamed combinationally in the cycle it is presented. The alias table and the free list change on the next clock edge. The rename stalls only when the free list holds fewer tags than the pair's destinations need.

Top module: `rename_unit`

## Requirements
- R1: After reset, the architectural index k (0..7 standing for r1..r8) maps to physical tags 12, 6, 9, 15, 1, 10, 8, 14 respectively. A source read returns these values until a rename overwrites them.
- R2: After reset the free list holds four tags, with 5 at the head, then 11, 13 and 4, and `fl_count` reads 4.
- R3: Each source tag equals the alias table entry of its architectural register as left by all earlier accepted renames.
- R4: Destination tags are taken from the free-list head in FIFO order. Slot 0 takes its tag before slot 1, and slot 1 takes the head when slot 0 needs none. The written register maps to the new tag from the next cycle on.
- R5: Each destination output carries the tag its register held before this rename (`prev_tag`).
- R6: When slot 1 reads a register that slot 0 writes in the same cycle, slot 1's source tag is slot 0's new destination tag.
- R7: When both slots write the same register, the alias table ends up holding slot 1's tag, and slot 1's `prev_tag` is slot 0's new tag.
- R8: `ren_stall` is 1 exactly when the number of valid slots with a destination exceeds `fl_count`. A stall drops both output valids, even when one tag would cover slot 0, and it leaves the alias table and the free-list contents unchanged.
- R9: An invalid slot, or a valid slot without a destination, takes no tag. A single slot with a destination renames when exactly one tag is free.
- R10: Retire pushes up to two tags per cycle at the free-list tail, release 0 before release 1. In the same cycle as allocations, `fl_count` moves by releases minus allocations.
- R11: Released tags are handed out again, in their release order, after the tags already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Slot 0 holds an instruction |
| in0_has_dst | input | 1 | Slot 0 writes a register |
| in0_src_a | input | 3 | Slot 0 first source, architectural index |
| in0_src_b | input | 3 | Slot 0 second source, architectural index |
| in0_dst | input | 3 | Slot 0 destination, architectural index |
| in1_valid | input | 1 | Slot 1 holds an instruction (younger) |
| in1_has_dst | input | 1 | Slot 1 writes a register |
| in1_src_a | input | 3 | Slot 1 first source |
| in1_src_b | input | 3 | Slot 1 second source |
| in1_dst | input | 3 | Slot 1 destination |
| rel0_valid | input | 1 | Release 0 carries a tag |
| rel0_tag | input | 4 | Release 0 physical tag |
| rel1_valid | input | 1 | Release 1 carries a tag |
| rel1_tag | input | 4 | Release 1 physical tag |
| ren_stall | output | 1 | Pair held back for lack of free tags |
| out0_valid | output | 1 | Slot 0 renamed this cycle |
| out0_src_a_tag | output | 4 | Slot 0 first source tag |
| out0_src_b_tag | output | 4 | Slot 0 second source tag |
| out0_dst_tag | output | 4 | Slot 0 new destination tag |
| out0_prev_tag | output | 4 | Slot 0 destination's previous tag |
| out1_valid | output | 1 | Slot 1 renamed this cycle |
| out1_src_a_tag | output | 4 | Slot 1 first source tag |
| out1_src_b_tag | output | 4 | Slot 1 second source tag |
| out1_dst_tag | output | 4 | Slot 1 new destination tag |
| out1_prev_tag | output | 4 | Slot 1 destination's previous tag |
| fl_count | output | 5 | Number of tags in the free list |

## Verification
The bench runs a four-instruction chain in which the same register is written twice across two pairs. A unit without the in-pair forward would hand slot 1 the stale alias-table tag, and a unit that let slot 0 win the table write would later read the wrong tag for the register. It presents pairs with only one or zero free tags. A unit that split the pair would emit slot 0 and consume a tag, and a unit that stalled too eagerly would block a lone instruction that one tag covers. Releases arrive in stall cycles and in allocating cycles, so a wrong count merge or a wrong tail order shows up as the wrong tag handed out several pairs later.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int NUM_ARCH  = 8;
    localparam int NUM_PHYS  = 16;
    localparam int AREG_W    = $clog2(NUM_ARCH);
    localparam int TAG_W     = $clog2(NUM_PHYS);
    localparam int FL_DEPTH  = NUM_PHYS;
    localparam int FL_PTR_W  = $clog2(FL_DEPTH);
    localparam int FL_CNT_W  = FL_PTR_W + 1;
    localparam int FL_INIT_N = 4;

    // Reset mapping of architectural register index k (r(k+1)).
    function automatic logic [TAG_W-1:0] rat_reset_tag(input int k);
        case (k)
            0:       return TAG_W'(12);
            1:       return TAG_W'(6);
            2:       return TAG_W'(9);
            3:       return TAG_W'(15);
            4:       return TAG_W'(1);
            5:       return TAG_W'(10);
            6:       return TAG_W'(8);
            7:       return TAG_W'(14);
            default: return '0;
        endcase
    endfunction

    // Free-list contents at reset, head first.
    function automatic logic [TAG_W-1:0] fl_reset_tag(input int k);
        case (k)
            0:       return TAG_W'(5);
            1:       return TAG_W'(11);
            2:       return TAG_W'(13);
            3:       return TAG_W'(4);
            default: return '0;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_ARCH-1:0][TAG_W-1:0] map;
    } rat_state_t;

    typedef struct packed {
        logic [FL_DEPTH-1:0][TAG_W-1:0] mem;
        logic [FL_PTR_W-1:0]            head;
        logic [FL_PTR_W-1:0]            tail;
        logic [FL_CNT_W-1:0]            cnt;
    } fl_state_t;

endpackage

// File: rtl/rename_rat.sv
module rename_rat
    import rename_pkg::*;
#(
    parameter int NUM_RD = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0][AREG_W-1:0] rd_areg,
    output logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
    input  logic                          wr0_en,
    input  logic [AREG_W-1:0]             wr0_areg,
    input  logic [TAG_W-1:0]              wr0_tag,
    input  logic                          wr1_en,
    input  logic [AREG_W-1:0]             wr1_areg,
    input  logic [TAG_W-1:0]              wr1_tag
);

    rat_state_t st_q, st_d;

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_tag[r] = st_q.map[rd_areg[r]];
    end

    always_comb begin
        st_d = st_q;
        if (wr0_en) st_d.map[wr0_areg] = wr0_tag;
        // the younger write lands last so it wins on a shared register
        if (wr1_en) st_d.map[wr1_areg] = wr1_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_ARCH; k++) st_q.map[k] <= rat_reset_tag(k);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
    import rename_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          pop_n,
    input  logic                push0_v,
    input  logic [TAG_W-1:0]    push0_tag,
    input  logic                push1_v,
    input  logic [TAG_W-1:0]    push1_tag,
    output logic [TAG_W-1:0]    head0_tag,
    output logic [TAG_W-1:0]    head1_tag,
    output logic [FL_CNT_W-1:0] count
);

    fl_state_t st_q, st_d;

    assign head0_tag = st_q.mem[st_q.head];
    assign head1_tag = st_q.mem[st_q.head + FL_PTR_W'(1)];
    assign count     = st_q.cnt;

    always_comb begin
        logic [FL_PTR_W-1:0] wptr;
        st_d = st_q;
        wptr = st_q.tail;
        if (push0_v) begin
            st_d.mem[wptr] = push0_tag;
            wptr           = wptr + FL_PTR_W'(1);
        end
        if (push1_v) begin
            st_d.mem[wptr] = push1_tag;
            wptr           = wptr + FL_PTR_W'(1);
        end
        st_d.tail = wptr;
        st_d.head = st_q.head + FL_PTR_W'(pop_n);
        st_d.cnt  = st_q.cnt + FL_CNT_W'(push0_v) + FL_CNT_W'(push1_v)
                    - FL_CNT_W'(pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < FL_DEPTH; k++) st_q.mem[k] <= fl_reset_tag(k);
            st_q.head <= '0;
            st_q.tail <= FL_PTR_W'(FL_INIT_N);
            st_q.cnt  <= FL_CNT_W'(FL_INIT_N);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in0_valid,
    input  logic                in0_has_dst,
    input  logic [AREG_W-1:0]   in0_src_a,
    input  logic [AREG_W-1:0]   in0_src_b,
    input  logic [AREG_W-1:0]   in0_dst,
    input  logic                in1_valid,
    input  logic                in1_has_dst,
    input  logic [AREG_W-1:0]   in1_src_a,
    input  logic [AREG_W-1:0]   in1_src_b,
    input  logic [AREG_W-1:0]   in1_dst,
    input  logic                rel0_valid,
    input  logic [TAG_W-1:0]    rel0_tag,
    input  logic                rel1_valid,
    input  logic [TAG_W-1:0]    rel1_tag,
    output logic                ren_stall,
    output logic                out0_valid,
    output logic [TAG_W-1:0]    out0_src_a_tag,
    output logic [TAG_W-1:0]    out0_src_b_tag,
    output logic [TAG_W-1:0]    out0_dst_tag,
    output logic [TAG_W-1:0]    out0_prev_tag,
    output logic                out1_valid,
    output logic [TAG_W-1:0]    out1_src_a_tag,
    output logic [TAG_W-1:0]    out1_src_b_tag,
    output logic [TAG_W-1:0]    out1_dst_tag,
    output logic [TAG_W-1:0]    out1_prev_tag,
    output logic [FL_CNT_W-1:0] fl_count
);

    localparam int NUM_RD = 6;

    logic [NUM_RD-1:0][AREG_W-1:0] rd_areg;
    logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag;
    logic [TAG_W-1:0]              head0_tag, head1_tag;
    logic                          need0, need1, accept;
    logic [1:0]                    need_n, pop_n;
    logic                          fwd_a, fwd_b, fwd_d;

    // read ports: slot0 a/b/dst, slot1 a/b/dst
    assign rd_areg = {in1_dst, in1_src_b, in1_src_a, in0_dst, in0_src_b, in0_src_a};

    assign need0  = in0_valid & in0_has_dst;
    assign need1  = in1_valid & in1_has_dst;
    assign need_n = {1'b0, need0} + {1'b0, need1};
    assign ren_stall = FL_CNT_W'(need_n) > fl_count;
    assign accept = ~ren_stall;
    assign pop_n  = accept ? need_n : 2'd0;

    assign fwd_a = need0 & (in1_src_a == in0_dst);
    assign fwd_b = need0 & (in1_src_b == in0_dst);
    assign fwd_d = need0 & (in1_dst   == in0_dst);

    always_comb begin
        out0_valid     = in0_valid & accept;
        out0_src_a_tag = rd_tag[0];
        out0_src_b_tag = rd_tag[1];
        out0_prev_tag  = rd_tag[2];
        out0_dst_tag   = head0_tag;

        out1_valid     = in1_valid & accept;
        out1_src_a_tag = fwd_a ? head0_tag : rd_tag[3];
        out1_src_b_tag = fwd_b ? head0_tag : rd_tag[4];
        out1_prev_tag  = fwd_d ? head0_tag : rd_tag[5];
        out1_dst_tag   = need0 ? head1_tag : head0_tag;
    end

    rename_rat #(.NUM_RD(NUM_RD)) u_rat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_areg  (rd_areg),
        .rd_tag   (rd_tag),
        .wr0_en   (accept & need0),
        .wr0_areg (in0_dst),
        .wr0_tag  (out0_dst_tag),
        .wr1_en   (accept & need1),
        .wr1_areg (in1_dst),
        .wr1_tag  (out1_dst_tag)
    );

    rename_freelist u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_n     (pop_n),
        .push0_v   (rel0_valid),
        .push0_tag (rel0_tag),
        .push1_v   (rel1_valid),
        .push1_tag (rel1_tag),
        .head0_tag (head0_tag),
        .head1_tag (head1_tag),
        .count     (fl_count)
    );

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk
    import rename_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in0_valid,
    input logic                in0_has_dst,
    input logic [AREG_W-1:0]   in0_dst,
    input logic                in1_valid,
    input logic                in1_has_dst,
    input logic [AREG_W-1:0]   in1_src_a,
    input logic                rel0_valid,
    input logic                rel1_valid,
    input logic                ren_stall,
    input logic                out0_valid,
    input logic [TAG_W-1:0]    out0_dst_tag,
    input logic                out1_valid,
    input logic [TAG_W-1:0]    out1_src_a_tag,
    input logic [TAG_W-1:0]    out1_dst_tag,
    input logic [FL_CNT_W-1:0] fl_count
);

    logic settled_q;
    always_ff @(posedge clk) begin
        if (!rst_n) settled_q <= 1'b0;
        else        settled_q <= 1'b1;
    end

    logic [FL_CNT_W-1:0] want_n, alloc_n, rel_n;
    assign want_n  = FL_CNT_W'(in0_valid & in0_has_dst) + FL_CNT_W'(in1_valid & in1_has_dst);
    assign alloc_n = FL_CNT_W'(out0_valid & in0_has_dst) + FL_CNT_W'(out1_valid & in1_has_dst);
    assign rel_n   = FL_CNT_W'(rel0_valid) + FL_CNT_W'(rel1_valid);

    // R8
    stall_when_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> (want_n > fl_count) && !out0_valid && !out1_valid);

    // R9
    lone_dst_proceeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in0_valid && !(in1_valid && in1_has_dst) && fl_count != '0) |-> out0_valid);

    // R10
    count_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settled_q |=> fl_count == $past(fl_count) + $past(rel_n) - $past(alloc_n));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= FL_CNT_W'(FL_DEPTH));

    // R4
    distinct_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_valid && in0_has_dst && out1_valid && in1_has_dst) |-> out0_dst_tag != out1_dst_tag);

    // R6
    pair_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out1_valid && in0_valid && in0_has_dst && in1_src_a == in0_dst)
            |-> out1_src_a_tag == out0_dst_tag);

endmodule

bind rename_unit rename_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in0_valid      (in0_valid),
    .in0_has_dst    (in0_has_dst),
    .in0_dst        (in0_dst),
    .in1_valid      (in1_valid),
    .in1_has_dst    (in1_has_dst),
    .in1_src_a      (in1_src_a),
    .rel0_valid     (rel0_valid),
    .rel1_valid     (rel1_valid),
    .ren_stall      (ren_stall),
    .out0_valid     (out0_valid),
    .out0_dst_tag   (out0_dst_tag),
    .out1_valid     (out1_valid),
    .out1_src_a_tag (out1_src_a_tag),
    .out1_dst_tag   (out1_dst_tag),
    .fl_count       (fl_count)
);

// File: tb/rename_unit_tb.sv
module rename_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    typedef struct packed {
        logic       v0; logic h0; logic [2:0] a0; logic [2:0] b0; logic [2:0] d0;
        logic       v1; logic h1; logic [2:0] a1; logic [2:0] b1; logic [2:0] d1;
        logic       r0v; logic [3:0] r0t; logic r1v; logic [3:0] r1t;
        logic       stall;
        logic [3:0] ea0; logic [3:0] eb0; logic [3:0] ed0; logic [3:0] ep0;
        logic [3:0] ea1; logic [3:0] eb1; logic [3:0] ed1; logic [3:0] ep1;
        logic [4:0] cnt;
    } vec_t;

    // expected values worked out from R1..R11, count sampled before the edge
    localparam vec_t VECS [NVEC] = '{
        '{1,1,1,2,0, 1,1,0,4,3, 0,0,0,0, 0, 6,9,5,12, 5,1,11,15, 4},
        '{1,1,5,6,0, 1,1,0,3,7, 0,0,0,0, 0, 10,8,13,5, 13,11,4,14, 2},
        '{1,1,0,0,1, 0,0,0,0,0, 1,12,1,15, 1, 0,0,0,0, 0,0,0,0, 0},
        '{1,0,0,7,0, 1,1,3,1,1, 0,0,0,0, 0, 13,4,0,0, 11,6,12,6, 2},
        '{1,1,0,0,0, 1,1,0,0,1, 1,5,1,14, 1, 0,0,0,0, 0,0,0,0, 1},
        '{1,1,1,2,2, 1,1,2,0,2, 1,9,0,0, 0, 12,9,15,9, 15,13,5,15, 3},
        '{1,0,2,3,0, 0,0,0,0,0, 0,0,0,0, 0, 5,11,0,0, 0,0,0,0, 2},
        '{0,0,0,0,0, 1,1,4,7,4, 0,0,0,0, 0, 0,0,0,0, 1,4,14,1, 2},
        '{1,1,4,5,5, 0,0,0,0,0, 0,0,0,0, 0, 14,10,9,10, 0,0,0,0, 1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic in0_valid, in0_has_dst, in1_valid, in1_has_dst;
    logic [2:0] in0_src_a, in0_src_b, in0_dst, in1_src_a, in1_src_b, in1_dst;
    logic rel0_valid, rel1_valid;
    logic [3:0] rel0_tag, rel1_tag;
    logic ren_stall, out0_valid, out1_valid;
    logic [3:0] out0_src_a_tag, out0_src_b_tag, out0_dst_tag, out0_prev_tag;
    logic [3:0] out1_src_a_tag, out1_src_b_tag, out1_dst_tag, out1_prev_tag;
    logic [4:0] fl_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_unit u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        in0_valid = 0; in0_has_dst = 0; in0_src_a = 0; in0_src_b = 0; in0_dst = 0;
        in1_valid = 0; in1_has_dst = 0; in1_src_a = 0; in1_src_b = 0; in1_dst = 0;
        rel0_valid = 0; rel0_tag = 0; rel1_valid = 0; rel1_tag = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    localparam int RESET_MAP [8] = '{12, 6, 9, 15, 1, 10, 8, 14};

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();

        // reset state
        #2;
        check("R2 reset count", fl_count, 4);
        check("R8 no stall idle", ren_stall, 0);
        for (int k = 0; k < 8; k++) begin
            in0_valid = 1; in0_src_a = 3'(k); in0_src_b = 3'(k);
            #1;
            check("R1 reset map", out0_src_a_tag, RESET_MAP[k]);
        end
        idle();

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            in0_valid = VECS[i].v0; in0_has_dst = VECS[i].h0;
            in0_src_a = VECS[i].a0; in0_src_b = VECS[i].b0; in0_dst = VECS[i].d0;
            in1_valid = VECS[i].v1; in1_has_dst = VECS[i].h1;
            in1_src_a = VECS[i].a1; in1_src_b = VECS[i].b1; in1_dst = VECS[i].d1;
            rel0_valid = VECS[i].r0v; rel0_tag = VECS[i].r0t;
            rel1_valid = VECS[i].r1v; rel1_tag = VECS[i].r1t;
            #2;
            check("R10 count", fl_count, VECS[i].cnt);
            check("R8 stall", ren_stall, VECS[i].stall);
            check("R8 slot0 valid", out0_valid, VECS[i].v0 & ~VECS[i].stall);
            check("R8 slot1 valid", out1_valid, VECS[i].v1 & ~VECS[i].stall);
            if (VECS[i].v0 && !VECS[i].stall) begin
                check("R3 slot0 src a", out0_src_a_tag, VECS[i].ea0);
                check("R3 slot0 src b", out0_src_b_tag, VECS[i].eb0);
                if (VECS[i].h0) begin
                    check("R4 slot0 dst", out0_dst_tag, VECS[i].ed0);
                    check("R5 slot0 prev", out0_prev_tag, VECS[i].ep0);
                end
            end
            if (VECS[i].v1 && !VECS[i].stall) begin
                check("R6 slot1 src a", out1_src_a_tag, VECS[i].ea1);
                check("R6 slot1 src b", out1_src_b_tag, VECS[i].eb1);
                if (VECS[i].h1) begin
                    check("R4 R11 slot1 dst", out1_dst_tag, VECS[i].ed1);
                    check("R7 slot1 prev", out1_prev_tag, VECS[i].ep1);
                end
            end
        end
        @(negedge clk);
        idle();
        #2;
        check("R9 count after lone rename", fl_count, 0);

        // R8: a pair needing one tag with none free stalls and changes nothing
        in0_valid = 1; in0_has_dst = 1; in0_dst = 3'd7;
        #1;
        check("R8 empty stall", ren_stall, 1);
        @(negedge clk);
        idle();
        in0_valid = 1; in0_src_a = 3'd7; #1;
        check("R8 map untouched", out0_src_a_tag, 4);

        // R10: two releases land in tail order, R11 reissue
        @(negedge clk);
        idle();
        rel0_valid = 1; rel0_tag = 4'd2; rel1_valid = 1; rel1_tag = 4'd3;
        @(negedge clk);
        idle();
        in0_valid = 1; in0_has_dst = 1; in0_dst = 3'd6;
        in1_valid = 1; in1_has_dst = 1; in1_dst = 3'd5; in1_src_a = 3'd6;
        #2;
        check("R10 count after release", fl_count, 2);
        check("R10 release 0 first", out0_dst_tag, 2);
        check("R11 release 1 next", out1_dst_tag, 3);
        check("R6 forward after release", out1_src_a_tag, 2);

        // re-reset restores everything
        do_reset();
        #2;
        check("R2 count after re-reset", fl_count, 4);
        in0_valid = 1; in0_has_dst = 1; in0_dst = 3'd0; #1;
        check("R2 head after re-reset", out0_dst_tag, 5);
        check("R1 prev after re-reset", out0_prev_tag, 12);
        idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule